// File: doc/BRIEF.md
# Streaming video line clipper

This block crops a packetized video stream to a rectangle set by software. Every field opens with a one-beat header packet that gives the field's width, height and an interlace flag. Each data packet after it carries exactly one video line, one pixel per beat. The block rewrites the header so it reports the clipped size. It discards lines that fall outside the window and trims the kept lines to the window's columns, producing fresh start and end markers for each trimmed line.

Software programs an offset and a requested size through a small register port. Those values sit in shadow registers until a commit is requested, either by a register write or by a commit packet arriving in the stream. A pending commit takes effect when the next field starts, so a field already in progress is never altered. The window is always limited by the actual input size, which means a field no larger than the window passes through unchanged. Debug registers report the most recent input size and a count of fields seen.

A build-time option selects a reduced mode. In that mode the stream carries no headers. Software writes the field size into input-size registers, and a field starts at the first line after the previous field's last line.

Top module: `vid_clip`

## Requirements
- R1: After reset no output beat is valid, and the registers read back as follows: offsets 0, requested width and height all ones, commit 0, input width 0, input height 0, field count 0.
- R2: Packet types on the sideband are 0 for data, 1 for header and 2 for commit. A header is a single beat whose bits [DIM_W-1:0] hold the width, bits [2*DIM_W-1:DIM_W] hold the height and bit 2*DIM_W holds the interlace flag. In the full mode each header is forwarded as one beat of type 1 with start and end both set. Its width and height fields are replaced by the effective clipped size, and its interlace bit is kept.
- R3: Lines are counted from 0 after each header. Only lines Y to Y+EH-1 are forwarded, where Y is the vertical offset and EH is the effective height. All other lines are dropped whole.
- R4: In a forwarded line only columns X to X+EW-1 are sent, with their pixel data unchanged. The start marker is set on column X and the end marker on column X+EW-1. The output type is 0.
- R5: The effective width EW is the smaller of the requested width and the input width minus X, and is 0 when X is not less than the input width. The effective height EH follows the same rule using the height values. A field no larger than the window therefore passes through unchanged, and a zero result drops every line.
- R6: Registers are addressed by word index: 0 horizontal offset, 1 vertical offset, 2 requested width, 3 requested height, 4 commit, 5 input width, 6 input height, 7 field count. Each read returns its data one cycle after the request. Writes to indices 0 to 3 do not affect the output. Writing 1 in bit 0 of index 4 marks a commit as pending. The commit register reads 1 while a commit is pending and 0 once the next field has started.
- R7: A type-2 packet in the stream marks a commit as pending, exactly like the commit register write, and is never forwarded.
- R8: A commit that becomes pending in the middle of a field leaves the rest of that field clipped with the old settings. The new settings apply from the next field.
- R9: Indices 5 and 6 read the size given by the most recent header, and index 7 counts the headers received since reset.
- R10: In the reduced mode, header packets are dropped. Indices 5 and 6 are writable and give the field size. A field starts at the first line after reset, and again after each group of input-height lines. Clipping otherwise follows R3 to R5, and index 7 counts the fields.
- R11: Under arbitrary output stalls no pixel is lost, duplicated or reordered. An input beat is accepted in the same cycle as its output beat, or without waiting when that beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid the cycle after reg_rd |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | PIX_W | Pixel or header payload |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_type | input | 2 | Packet type: 0 data, 1 header, 2 commit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | PIX_W | Pixel or rewritten header |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |
| out_type | output | 2 | Packet type of the output beat |

## Verification
The bench builds two copies of the block with DIM_W=6 and PIX_W=16: one in the full mode and one in the reduced mode. With a 6-bit size field, a 6x4 input can be swept through every interesting relation between offset, requested size and input size. The sweep covers windows that fit inside the field, windows that stick out past its edge, offsets on or past the edge that give zero output, and exact passthrough. The pixel payload encodes the line and column, so every output beat can be predicted arithmetically even while the output is stalled at random.

// File: rtl/vclip_pkg.sv
package vclip_pkg;
  localparam logic [1:0] PT_DATA = 2'd0;
  localparam logic [1:0] PT_HDR  = 2'd1;
  localparam logic [1:0] PT_CMT  = 2'd2;

  localparam logic [2:0] RI_X   = 3'd0;
  localparam logic [2:0] RI_Y   = 3'd1;
  localparam logic [2:0] RI_W   = 3'd2;
  localparam logic [2:0] RI_H   = 3'd3;
  localparam logic [2:0] RI_CMT = 3'd4;
  localparam logic [2:0] RI_IW  = 3'd5;
  localparam logic [2:0] RI_IH  = 3'd6;
  localparam logic [2:0] RI_FC  = 3'd7;
endpackage

// File: rtl/vclip_regs.sv
module vclip_regs
  import vclip_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int REG_W = 32,
  parameter int CNT_W = 16,
  parameter bit LITE  = 1'b0,
  parameter bit DEBUG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             commit_pkt,
  input  logic             frame_start,
  input  logic [DIM_W-1:0] seen_w,
  input  logic [DIM_W-1:0] seen_h,
  output logic [DIM_W-1:0] shd_x,
  output logic [DIM_W-1:0] shd_y,
  output logic [DIM_W-1:0] shd_w,
  output logic [DIM_W-1:0] shd_h,
  output logic             pend,
  output logic [DIM_W-1:0] lite_w,
  output logic [DIM_W-1:0] lite_h
);
  logic [CNT_W-1:0] fcount;
  logic             set_pend;
  logic [DIM_W-1:0] rb_w, rb_h;
  logic [CNT_W-1:0] rb_fc;

  assign set_pend = (reg_wr && reg_idx == RI_CMT && reg_wdata[0]) || commit_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_x  <= '0;
      shd_y  <= '0;
      shd_w  <= '1;
      shd_h  <= '1;
      pend   <= 1'b0;
      lite_w <= '0;
      lite_h <= '0;
      fcount <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_idx)
          RI_X: shd_x <= reg_wdata[DIM_W-1:0];
          RI_Y: shd_y <= reg_wdata[DIM_W-1:0];
          RI_W: shd_w <= reg_wdata[DIM_W-1:0];
          RI_H: shd_h <= reg_wdata[DIM_W-1:0];
          RI_IW: if (LITE) lite_w <= reg_wdata[DIM_W-1:0];
          RI_IH: if (LITE) lite_h <= reg_wdata[DIM_W-1:0];
          default: ;
        endcase
      end
      if (set_pend)         pend <= 1'b1;
      else if (frame_start) pend <= 1'b0;
      if (frame_start) fcount <= fcount + 1'b1;
    end
  end

  generate
    if (LITE) begin : g_rb_lite
      assign rb_w = lite_w;
      assign rb_h = lite_h;
    end else if (DEBUG) begin : g_rb_dbg
      assign rb_w = seen_w;
      assign rb_h = seen_h;
    end else begin : g_rb_none
      assign rb_w = '0;
      assign rb_h = '0;
    end
    if (DEBUG || LITE) begin : g_fc
      assign rb_fc = fcount;
    end else begin : g_fc_none
      assign rb_fc = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_idx)
        RI_X:   reg_rdata[DIM_W-1:0] <= shd_x;
        RI_Y:   reg_rdata[DIM_W-1:0] <= shd_y;
        RI_W:   reg_rdata[DIM_W-1:0] <= shd_w;
        RI_H:   reg_rdata[DIM_W-1:0] <= shd_h;
        RI_CMT: reg_rdata[0]         <= pend;
        RI_IW:  reg_rdata[DIM_W-1:0] <= rb_w;
        RI_IH:  reg_rdata[DIM_W-1:0] <= rb_h;
        default: reg_rdata[CNT_W-1:0] <= rb_fc;
      endcase
    end
  end

  // R6: a started field with no new request leaves nothing pending
  assert_commit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !set_pend) |=> !pend);
  // R7: a commit packet always leaves a commit pending
  assert_commit_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pkt |=> pend);
endmodule

// File: rtl/vclip_stream.sv
module vclip_stream
  import vclip_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int PIX_W = 32,
  parameter bit LITE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [1:0]       in_type,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [1:0]       out_type,
  input  logic [DIM_W-1:0] shd_x,
  input  logic [DIM_W-1:0] shd_y,
  input  logic [DIM_W-1:0] shd_w,
  input  logic [DIM_W-1:0] shd_h,
  input  logic             pend,
  input  logic [DIM_W-1:0] lite_w,
  input  logic [DIM_W-1:0] lite_h,
  output logic             frame_start,
  output logic             commit_pkt,
  output logic [DIM_W-1:0] seen_w,
  output logic [DIM_W-1:0] seen_h
);
  localparam int XW = DIM_W + 1;

  function automatic logic [DIM_W-1:0] clip_len(
    input logic [DIM_W-1:0] req, input logic [DIM_W-1:0] total, input logic [DIM_W-1:0] off);
    logic [DIM_W-1:0] room;
    room = (off >= total) ? '0 : total - off;
    return (req < room) ? req : room;
  endfunction

  function automatic logic in_span(
    input logic [DIM_W-1:0] pos, input logic [DIM_W-1:0] start, input logic [DIM_W-1:0] len);
    logic [XW-1:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < stop);
  endfunction

  logic [DIM_W-1:0] act_x, act_y, act_rw, act_rh, act_ew, act_eh, fh_q;
  logic [DIM_W-1:0] col_q, line_q, col;
  logic [DIM_W-1:0] fr_w, fr_h, sel_x, sel_y, sel_w, sel_h, new_ew, new_eh;
  logic [DIM_W-1:0] cur_x, cur_y, cur_ew, cur_eh, cur_fh;
  logic             is_dat, is_hdr, is_cmt, fs_cand, keep, xfer, last_col;
  logic [PIX_W-1:0] hdr_out;

  always_comb begin
    is_dat  = (in_type == PT_DATA);
    is_hdr  = (in_type == PT_HDR);
    is_cmt  = (in_type == PT_CMT);
    fr_w    = LITE ? lite_w : in_data[DIM_W-1:0];
    fr_h    = LITE ? lite_h : in_data[2*DIM_W-1:DIM_W];
    fs_cand = LITE ? (in_valid && is_dat && in_sop && line_q == '0) : (in_valid && is_hdr);
    sel_x   = pend ? shd_x : act_x;
    sel_y   = pend ? shd_y : act_y;
    sel_w   = pend ? shd_w : act_rw;
    sel_h   = pend ? shd_h : act_rh;
    new_ew  = clip_len(sel_w, fr_w, sel_x);
    new_eh  = clip_len(sel_h, fr_h, sel_y);
    cur_x   = fs_cand ? sel_x  : act_x;
    cur_y   = fs_cand ? sel_y  : act_y;
    cur_ew  = fs_cand ? new_ew : act_ew;
    cur_eh  = fs_cand ? new_eh : act_eh;
    cur_fh  = fs_cand ? fr_h   : fh_q;
    col     = in_sop ? '0 : col_q;
    keep    = (is_hdr && !LITE) ||
              (is_dat && in_span(col, cur_x, cur_ew) && in_span(line_q, cur_y, cur_eh));
    last_col = ({1'b0, col} + 1'b1) == ({1'b0, cur_x} + {1'b0, cur_ew});
    hdr_out = '0;
    hdr_out[DIM_W-1:0]       = new_ew;
    hdr_out[2*DIM_W-1:DIM_W] = new_eh;
    hdr_out[2*DIM_W]         = in_data[2*DIM_W];
  end

  assign in_ready    = out_ready || !keep;
  assign xfer        = in_valid && in_ready;
  assign frame_start = fs_cand && in_ready;
  assign commit_pkt  = xfer && is_cmt;
  assign out_valid   = in_valid && keep;
  assign out_type    = in_type;
  assign out_data    = is_hdr ? hdr_out : in_data;
  assign out_sop     = is_hdr ? 1'b1 : (col == cur_x);
  assign out_eop     = is_hdr ? 1'b1 : last_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_x <= '0; act_y <= '0; act_rw <= '1; act_rh <= '1;
      act_ew <= '1; act_eh <= '1; fh_q <= '0;
      col_q <= '0; line_q <= '0; seen_w <= '0; seen_h <= '0;
    end else begin
      if (frame_start) begin
        act_x <= sel_x; act_y <= sel_y; act_rw <= sel_w; act_rh <= sel_h;
        act_ew <= new_ew; act_eh <= new_eh; fh_q <= fr_h;
        seen_w <= fr_w; seen_h <= fr_h;
      end
      if (xfer && is_hdr && !LITE) begin
        col_q  <= '0;
        line_q <= '0;
      end else if (xfer && is_dat) begin
        col_q <= in_eop ? '0 : col + 1'b1;
        if (in_eop)
          line_q <= (LITE && ({1'b0, line_q} + 1'b1) == {1'b0, cur_fh}) ? '0 : line_q + 1'b1;
      end
    end
  end

  // checker state: beats and lines actually delivered downstream
  logic [XW-1:0]    ocnt;
  logic [DIM_W-1:0] oline;
  logic             odat;
  assign odat = out_valid && out_ready && out_type == PT_DATA;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt <= '0; oline <= '0;
    end else begin
      if (out_valid && out_ready && out_type == PT_HDR) oline <= '0;
      else if (odat && out_eop) oline <= oline + 1'b1;
      if (odat) ocnt <= out_eop ? '0 : ocnt + 1'b1;
    end
  end

  // R4: each delivered line holds exactly the effective width
  assert_line_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (odat && out_eop) |-> (ocnt + 1'b1 == {1'b0, cur_ew}));
  // R4: the start marker only opens a line
  assert_sop_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (odat && out_sop) |-> (ocnt == '0));
  // R3: never more lines than the effective height
  assert_line_count_R3: assert property (@(posedge clk) disable iff (!rst_n || LITE)
    odat |-> (oline < cur_eh));
  // R5: rewritten header size never exceeds the incoming size
  assert_hdr_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == PT_HDR) |->
      (out_data[DIM_W-1:0] <= in_data[DIM_W-1:0] &&
       out_data[2*DIM_W-1:DIM_W] <= in_data[2*DIM_W-1:DIM_W]));
  // R11: a stalled kept beat is never consumed
  assert_no_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/vid_clip.sv
module vid_clip
  import vclip_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int PIX_W = 32,
  parameter int REG_W = 32,
  parameter int CNT_W = 16,
  parameter bit LITE  = 1'b0,
  parameter bit DEBUG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [1:0]       in_type,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [1:0]       out_type
);
  initial begin
    assert (PIX_W >= 2 * DIM_W + 1) else $error("header does not fit in PIX_W");
    assert (REG_W >= CNT_W && CNT_W >= DIM_W) else $error("register width too small");
  end

  logic [DIM_W-1:0] shd_x, shd_y, shd_w, shd_h, lite_w, lite_h, seen_w, seen_h;
  logic             pend, frame_start, commit_pkt;

  vclip_regs #(.DIM_W(DIM_W), .REG_W(REG_W), .CNT_W(CNT_W), .LITE(LITE), .DEBUG(DEBUG)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit_pkt(commit_pkt),
    .frame_start(frame_start), .seen_w(seen_w), .seen_h(seen_h),
    .shd_x(shd_x), .shd_y(shd_y), .shd_w(shd_w), .shd_h(shd_h), .pend(pend),
    .lite_w(lite_w), .lite_h(lite_h));

  vclip_stream #(.DIM_W(DIM_W), .PIX_W(PIX_W), .LITE(LITE)) u_stream (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_type(in_type), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_type(out_type), .shd_x(shd_x), .shd_y(shd_y), .shd_w(shd_w), .shd_h(shd_h),
    .pend(pend), .lite_w(lite_w), .lite_h(lite_h), .frame_start(frame_start),
    .commit_pkt(commit_pkt), .seen_w(seen_w), .seen_h(seen_h));
endmodule

// File: tb/vid_clip_test.sv
module vid_clip_test;
  localparam int DW = 6;
  localparam int PW = 16;

  typedef struct packed {
    logic [PW-1:0] d;
    logic          s;
    logic          e;
    logic [1:0]    t;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0;
  logic [PW-1:0] in_data = '0;
  logic [1:0] in_type = '0;
  logic sel = 1'b0;

  logic [31:0] rd0, rd1;
  logic ir0, ir1, ov0, ov1, os0, os1, oe0, oe1;
  logic [PW-1:0] od0, od1;
  logic [1:0] ot0, ot1;

  wire [31:0]   m_rdata = sel ? rd1 : rd0;
  wire          m_ready = sel ? ir1 : ir0;
  wire          m_valid = sel ? ov1 : ov0;
  wire beat_t   m_beat  = sel ? beat_t'{od1, os1, oe1, ot1} : beat_t'{od0, os0, oe0, ot0};

  always #4 clk = ~clk;

  vid_clip #(.DIM_W(DW), .PIX_W(PW), .LITE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .in_valid(in_valid), .in_ready(ir0),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_type(in_type),
    .out_valid(ov0), .out_ready(out_ready), .out_data(od0), .out_sop(os0),
    .out_eop(oe0), .out_type(ot0));

  vid_clip #(.DIM_W(DW), .PIX_W(PW), .LITE(1'b1)) uut_lite (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(rd1), .in_valid(in_valid), .in_ready(ir1),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_type(in_type),
    .out_valid(ov1), .out_ready(out_ready), .out_data(od1), .out_sop(os1),
    .out_eop(oe1), .out_type(ot1));

  int checks = 0, fails = 0;
  bit done = 0;
  beat_t inq[$];
  beat_t expq[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int win(int req, int total, int off);
    int r;
    r = total - off;
    if (r < 0) r = 0;
    return (req < r) ? req : r;
  endfunction

  function automatic logic [PW-1:0] pix(int l, int c);
    return 16'h8000 | PW'(l << 6) | PW'(c);
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic reg_write(int idx, int val);
    @(negedge clk);
    reg_wr = 1; reg_idx = 3'(idx); reg_wdata = 32'(val);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(int idx, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_idx = 3'(idx);
    @(negedge clk);
    reg_rd = 0;
    v = m_rdata;
  endtask

  task automatic expect_reg(int idx, int val, string tag);
    logic [31:0] v;
    reg_read(idx, v);
    chk(v == 32'(val), tag, v, 32'(val));
  endtask

  task automatic set_window(int x, int y, int w, int h, bit commit);
    reg_write(0, x); reg_write(1, y); reg_write(2, w); reg_write(3, h);
    if (commit) reg_write(4, 1);
  endtask

  // one field: header (optional), lines, optional commit packet after line cmt_after
  task automatic gen_frame(int iw, int ih, int il, int x, int y, int cw, int ch,
                           bit hdr, int cmt_after);
    int ew, eh;
    ew = win(cw, iw, x);
    eh = win(ch, ih, y);
    if (hdr) begin
      inq.push_back(beat_t'{PW'((il << 12) | (ih << 6) | iw), 1'b1, 1'b1, 2'd1});
      expq.push_back(beat_t'{PW'((il << 12) | (eh << 6) | ew), 1'b1, 1'b1, 2'd1});
    end
    for (int l = 0; l < ih; l++) begin
      for (int c = 0; c < iw; c++) begin
        inq.push_back(beat_t'{pix(l, c), c == 0, c == iw - 1, 2'd0});
        if (l >= y && l < y + eh && c >= x && c < x + ew)
          expq.push_back(beat_t'{pix(l, c), c == x, c == x + ew - 1, 2'd0});
      end
      if (l == cmt_after) inq.push_back(beat_t'{PW'(0), 1'b1, 1'b1, 2'd2});
    end
  endtask

  task automatic run(string tag);
    int guard = 0;
    while ((inq.size() > 0 || expq.size() > 0) && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (inq.size() > 0) begin
        in_valid = 1;
        {in_data, in_sop, in_eop, in_type} = inq[0];
      end else begin
        in_valid = 0;
      end
      out_ready = ($urandom % 4) != 0;
      #2;
      if (m_valid && out_ready) begin
        if (expq.size() == 0) chk(0, {tag, " extra beat"}, 32'(m_beat), 0);
        else begin
          chk(m_beat == expq[0], tag, 32'(m_beat), 32'(expq[0]));
          void'(expq.pop_front());
        end
      end
      if (in_valid && m_ready) void'(inq.pop_front());
    end
    @(negedge clk);
    in_valid = 0;
    chk(expq.size() == 0 && inq.size() == 0, {tag, " leftover"}, 32'(expq.size()), 0);
    expq.delete();
    inq.delete();
  endtask

  initial begin
    int xs[4] = '{0, 2, 5, 6};
    int ys[4] = '{0, 1, 3, 4};
    int ws[3] = '{1, 3, 6};
    int hs[3] = '{1, 2, 4};
    int n = 0;
    do_reset();
    // R1 reset state
    #2 chk(ov0 == 0 && ov1 == 0, "R1 out_valid", 32'(ov0), 0);
    expect_reg(0, 0, "R1 X");
    expect_reg(1, 0, "R1 Y");
    expect_reg(2, 63, "R1 W");
    expect_reg(3, 63, "R1 H");
    expect_reg(4, 0, "R1 COMMIT");
    expect_reg(5, 0, "R1 IN_W");
    expect_reg(6, 0, "R1 IN_H");
    expect_reg(7, 0, "R1 FC");
    // R5/R2 passthrough with defaults
    gen_frame(6, 4, 1, 0, 0, 63, 63, 1, -1);
    run("R5 R2 passthrough");
    // R6 staged writes have no effect
    set_window(1, 1, 2, 2, 0);
    expect_reg(4, 0, "R6 no pending");
    gen_frame(6, 4, 0, 0, 0, 63, 63, 1, -1);
    run("R6 uncommitted");
    reg_write(4, 1);
    expect_reg(4, 1, "R6 pending");
    gen_frame(6, 4, 0, 1, 1, 2, 2, 1, -1);
    run("R6 committed");
    expect_reg(4, 0, "R6 cleared");
    // R9 debug
    expect_reg(5, 6, "R9 IN_W");
    expect_reg(6, 4, "R9 IN_H");
    expect_reg(7, 3, "R9 FC");
    // R7 R8 commit packet mid field
    set_window(0, 0, 3, 3, 0);
    gen_frame(6, 4, 0, 1, 1, 2, 2, 1, 1);
    run("R8 mid-field commit packet");
    expect_reg(4, 1, "R7 packet pending");
    gen_frame(5, 4, 1, 0, 0, 3, 3, 1, -1);
    run("R7 applied next field");
    expect_reg(5, 5, "R9 IN_W new");
    // R3 R4 R5 R11 sweep under stalls
    foreach (xs[a]) foreach (ys[b]) foreach (ws[c]) foreach (hs[d]) begin
      set_window(xs[a], ys[b], ws[c], hs[d], 1);
      gen_frame(6, 4, n % 2, xs[a], ys[b], ws[c], hs[d], 1, -1);
      run("R3 R4 R11 sweep");
      n++;
    end
    expect_reg(7, 5 + n, "R9 FC sweep");
    // R10 reduced mode
    sel = 1;
    do_reset();
    reg_write(5, 5);
    reg_write(6, 3);
    expect_reg(5, 5, "R10 IN_W");
    set_window(1, 1, 3, 1, 1);
    inq.push_back(beat_t'{PW'(12'h0c5), 1'b1, 1'b1, 2'd1});
    gen_frame(5, 3, 0, 1, 1, 3, 1, 0, -1);
    gen_frame(5, 3, 0, 1, 1, 3, 1, 0, -1);
    run("R10 lite fields");
    expect_reg(7, 2, "R10 FC");
    expect_reg(4, 0, "R10 COMMIT");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule